// File: doc/BRIEF.md
# Fill Write-Back and Data-Bus Ownership Controller

This block sits between a processor's cache-RAM port and the system's memory interface. It keeps the cache index of up to two outstanding load misses in two slots. When the system announces returning data (a fill) it selects one slot with a one-bit identifier, drives that slot's index onto the cache RAM and writes the data. If the system has not yet acknowledged the data, the block repeats the write until it has. Returned data is checked for even byte parity. Parity checking can be switched off for a single transfer. A system-reported fill error raises a machine-check pulse.

The block also decides, one cycle ahead, whether the processor drives the shared 128-bit data bus. The system requests the bus by asserting a bus-request line, and the block releases the bus on the following edge. An idle-cache input lets the system hold off new cache RAM accesses while any access already started runs to its end. Processor-side cache reads take the RAM only when no fill is waiting.

Top module: `fill_bus_ctrl`

## Requirements
- R1: The bus drive enable in the cycle after a clock edge is the inverse of the bus-request input sampled at that edge (request high means release the bus); it is low during reset.
- R2: A fill sampled at an edge for a busy slot (fill-id 0 selects slot 0, fill-id 1 selects slot 1) makes the RAM write enable high in the next cycle, with the cache index equal to that slot's stored miss index.
- R3: If data acknowledge is low during a write cycle, the write enable is low for exactly one cycle and then rises again with the same index; this repeats until acknowledge is seen in a write cycle.
- R4: Data acknowledge high in a write cycle completes the fill: the write enable falls in the next cycle and the slot's busy bit clears.
- R5: While idle-cache is high no new write or read starts, including a write retry; a fill sampled in that time is held and its write starts at the first edge at which idle-cache is low. A write already in its cycle completes.
- R6: A miss request is stored in the lowest-numbered free slot, which becomes busy. The grant output is high when any slot is free. A request made while both slots are busy is ignored and leaves the busy bits unchanged.
- R7: In a fill data cycle (write cycle with acknowledge high), check bit k must equal the XOR of data bits 8k+7..8k (even parity over the byte and its check bit). Any mismatch makes the parity-error output high for the one cycle after that edge.
- R8: A fill data cycle with fill-nocheck high never raises the parity-error output, whatever the data and check bits.
- R9: Fill-error high in a fill data cycle raises the machine-check output for the one following cycle, and every such data cycle gives its own pulse.
- R10: A read request sampled while the RAM is free and idle-cache is low makes the RAM output enable high for one cycle with the cache index equal to the read index. A pending fill has priority over a read. The output enable and the write enable are never high together.
- R11: After reset both slots are free and the write enable, output enable, parity-error and machine-check outputs are low.
- R12: A fill whose selected slot is free is ignored and starts no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_req_in | input | 1 | Record a new outstanding miss |
| miss_addr_in | input | IDX_W | Cache index of the new miss |
| miss_grant_out | output | 1 | A slot is free for a new miss |
| slot_busy_out | output | 2 | Busy bit per miss slot |
| fill_in | input | 1 | Fill announcement from the system |
| fill_id_in | input | 1 | Slot selected by the fill |
| dack_in | input | 1 | Data acknowledge for the current write cycle |
| bus_req_in | input | 1 | System asks for the data bus |
| cache_idle_in | input | 1 | Hold off new cache RAM accesses |
| nocheck_in | input | 1 | Skip parity check for this data cycle |
| fill_err_in | input | 1 | System-detected error on returned data |
| data_in | input | DATA_W | Returned fill data |
| check_in | input | DATA_W/8 | Even parity bit per data byte |
| rd_req_in | input | 1 | Processor cache read request |
| rd_idx_in | input | IDX_W | Index for the cache read |
| idx_out | output | IDX_W | Cache RAM index |
| ram_we_out | output | 1 | Cache RAM write enable |
| ram_oe_out | output | 1 | Cache RAM output enable |
| bus_drive_out | output | 1 | Processor may drive the data bus |
| par_err_out | output | 1 | Parity error seen in the last data cycle |
| mchk_out | output | 1 | Machine-check pulse |

## Verification
Every result here is due exactly one edge after the stimulus that causes it. The bus-drive enable, the start of a write or read, the parity and machine-check pulses and the busy-bit changes all follow this rule. The grant output is combinational on the busy bits. The bench drives inputs just after the falling edge. Its behavioural model updates on the same rising edge as the design and is compared at the next falling edge, so each expected value is checked in the cycle it must appear. Named checks repeat this one cycle after the relevant stimulus for retries, deferred fills under idle-cache, ignored fills and suppressed parity checks.

// File: rtl/fbc_pkg.sv
// Shared types for the fill write-back controller.
// Assumes: fill sequencing needs only four RAM-side states.
package fbc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_READ  = 2'd3
    } fbc_state_e;
endpackage

// File: rtl/fbc_miss_regs.sv
// Miss slots: hold the cache index of each outstanding load miss.
// Loads go to the lowest free slot. A slot is freed when its fill completes.
// Assumes: a freed slot and a newly loaded slot never coincide on one edge,
// because a load only targets slots that were free before the edge.
module fbc_miss_regs #(
    parameter int IDX_W = 22,
    parameter int SLOTS = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_req,
    input  logic [IDX_W-1:0]         load_addr,
    input  logic                     free_en,
    input  logic [$clog2(SLOTS)-1:0] free_slot,
    input  logic [$clog2(SLOTS)-1:0] rd_slot,
    output logic [SLOTS-1:0]         busy,
    output logic [IDX_W-1:0]         rd_addr,
    output logic                     grant
);
    localparam int SLOT_W = $clog2(SLOTS);

    logic [IDX_W-1:0]  addr_q [SLOTS];
    logic [SLOTS-1:0]  busy_q;
    logic [SLOT_W-1:0] pick;
    logic              found;
    logic              load_en;

    // Choose the lowest-numbered free slot for an incoming miss.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!busy_q[i] && !found) begin
                found = 1'b1;
                pick  = SLOT_W'(i);
            end
        end
    end

    assign load_en = load_req && found;
    assign grant   = found;
    assign busy    = busy_q;
    assign rd_addr = addr_q[rd_slot];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        // Per-slot storage: set on load, clear on fill completion.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_q[g] <= 1'b0;
                addr_q[g] <= '0;
            end else if (load_en && pick == SLOT_W'(g)) begin
                busy_q[g] <= 1'b1;
                addr_q[g] <= load_addr;
            end else if (free_en && free_slot == SLOT_W'(g)) begin
                busy_q[g] <= 1'b0;
            end
        end

        // R4
        free_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (free_en && free_slot == SLOT_W'(g)) |=> !busy_q[g]);
    end

    // R6
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&busy_q && !free_en) |=> $stable(busy_q));
endmodule

// File: rtl/fbc_parity_chk.sv
// Even byte parity checker for returned fill data.
// Check bit k covers data byte k. Purely combinational.
// Assumes: DATA_W is a multiple of 8.
module fbc_parity_chk #(
    parameter int DATA_W = 128
) (
    input  logic [DATA_W-1:0]   data,
    input  logic [DATA_W/8-1:0] check,
    output logic                bad
);
    localparam int NB = DATA_W / 8;

    logic [NB-1:0] byte_bad;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        // One parity tree per byte: byte plus its check bit must XOR to zero.
        assign byte_bad[b] = ^{data[8*b +: 8], check[b]};
    end

    assign bad = |byte_bad;
endmodule

// File: rtl/fbc_fill_fsm.sv
// RAM-side sequencer. It starts fill writes and reads, retries a write until
// acknowledged, holds a fill while idle-cache is asserted, and flags parity and
// fill errors on data cycles.
// Assumes: at most one fill waits while another is being written.
module fbc_fill_fsm
    import fbc_pkg::*;
#(
    parameter int IDX_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_in,
    input  logic             fill_id_in,
    input  logic [1:0]       busy,
    input  logic [IDX_W-1:0] slot_addr,
    input  logic             dack_in,
    input  logic             cache_idle_in,
    input  logic             rd_req_in,
    input  logic [IDX_W-1:0] rd_idx_in,
    input  logic             nocheck_in,
    input  logic             fill_err_in,
    input  logic             par_bad,
    output logic             pick_slot,
    output logic             free_en,
    output logic             free_slot,
    output logic [IDX_W-1:0] idx_o,
    output logic             ram_we_o,
    output logic             ram_oe_o,
    output logic             par_err_o,
    output logic             mchk_o
);
    fbc_state_e state_q;
    logic       pend_q;
    logic       pend_slot_q;
    logic       cur_q;
    logic       live;
    logic       cand_v;
    logic       cand_slot;
    logic       data_cycle;

    // Candidate fill: a held one first, otherwise a fresh fill for a busy slot.
    always_comb begin
        live       = fill_in && busy[fill_id_in];
        cand_v     = pend_q || live;
        cand_slot  = pend_q ? pend_slot_q : fill_id_in;
        data_cycle = (state_q == ST_WRITE) && dack_in;
    end

    assign pick_slot = cand_slot;
    assign free_en   = data_cycle;
    assign free_slot = cur_q;

    // State, enables and error pulses for the cache RAM port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pend_q      <= 1'b0;
            pend_slot_q <= 1'b0;
            cur_q       <= 1'b0;
            idx_o       <= '0;
            ram_we_o    <= 1'b0;
            ram_oe_o    <= 1'b0;
            par_err_o   <= 1'b0;
            mchk_o      <= 1'b0;
        end else begin
            par_err_o <= data_cycle && !nocheck_in && par_bad;
            mchk_o    <= data_cycle && fill_err_in;
            ram_we_o  <= 1'b0;
            ram_oe_o  <= 1'b0;
            unique case (state_q)
                ST_IDLE, ST_READ: begin
                    if (cand_v && !cache_idle_in) begin
                        state_q  <= ST_WRITE;
                        ram_we_o <= 1'b1;
                        idx_o    <= slot_addr;
                        cur_q    <= cand_slot;
                        pend_q   <= 1'b0;
                    end else if (cand_v) begin
                        pend_q      <= 1'b1;
                        pend_slot_q <= cand_slot;
                        state_q     <= ST_IDLE;
                    end else if (rd_req_in && !cache_idle_in) begin
                        state_q  <= ST_READ;
                        ram_oe_o <= 1'b1;
                        idx_o    <= rd_idx_in;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_WRITE: begin
                    if (live && !pend_q) begin
                        pend_q      <= 1'b1;
                        pend_slot_q <= fill_id_in;
                    end
                    state_q <= dack_in ? ST_IDLE : ST_WAIT;
                end
                ST_WAIT: begin
                    if (live && !pend_q) begin
                        pend_q      <= 1'b1;
                        pend_slot_q <= fill_id_in;
                    end
                    if (!cache_idle_in) begin
                        state_q  <= ST_WRITE;
                        ram_we_o <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R3
    nodack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && !dack_in) |=> (state_q == ST_WAIT && !ram_we_o));

    // R9
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && dack_in && fill_err_in) |=> mchk_o);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_idle_in && state_q != ST_WRITE) |=> (!ram_we_o && !ram_oe_o));

    // R12
    free_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_in && !busy[fill_id_in] && !pend_q && state_q != ST_WAIT) |=> !ram_we_o);
endmodule

// File: rtl/fill_bus_ctrl.sv
// Top level: miss slots, fill sequencer, parity checker and the one-cycle-ahead
// data-bus ownership register.
// Assumes: all inputs are synchronous to clk. fill_id_in picks one of two slots.
module fill_bus_ctrl #(
    parameter int IDX_W  = 22,
    parameter int DATA_W = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                miss_req_in,
    input  logic [IDX_W-1:0]    miss_addr_in,
    output logic                miss_grant_out,
    output logic [1:0]          slot_busy_out,
    input  logic                fill_in,
    input  logic                fill_id_in,
    input  logic                dack_in,
    input  logic                bus_req_in,
    input  logic                cache_idle_in,
    input  logic                nocheck_in,
    input  logic                fill_err_in,
    input  logic [DATA_W-1:0]   data_in,
    input  logic [DATA_W/8-1:0] check_in,
    input  logic                rd_req_in,
    input  logic [IDX_W-1:0]    rd_idx_in,
    output logic [IDX_W-1:0]    idx_out,
    output logic                ram_we_out,
    output logic                ram_oe_out,
    output logic                bus_drive_out,
    output logic                par_err_out,
    output logic                mchk_out
);
    localparam int SLOTS = 2;

    logic [SLOTS-1:0] busy;
    logic [IDX_W-1:0] slot_addr;
    logic             pick_slot;
    logic             free_en;
    logic             free_slot;
    logic             par_bad;

    fbc_miss_regs #(.IDX_W(IDX_W), .SLOTS(SLOTS)) u_miss (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_req  (miss_req_in),
        .load_addr (miss_addr_in),
        .free_en   (free_en),
        .free_slot (free_slot),
        .rd_slot   (pick_slot),
        .busy      (busy),
        .rd_addr   (slot_addr),
        .grant     (miss_grant_out)
    );

    fbc_parity_chk #(.DATA_W(DATA_W)) u_par (
        .data  (data_in),
        .check (check_in),
        .bad   (par_bad)
    );

    fbc_fill_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .fill_in       (fill_in),
        .fill_id_in    (fill_id_in),
        .busy          (busy),
        .slot_addr     (slot_addr),
        .dack_in       (dack_in),
        .cache_idle_in (cache_idle_in),
        .rd_req_in     (rd_req_in),
        .rd_idx_in     (rd_idx_in),
        .nocheck_in    (nocheck_in),
        .fill_err_in   (fill_err_in),
        .par_bad       (par_bad),
        .pick_slot     (pick_slot),
        .free_en       (free_en),
        .free_slot     (free_slot),
        .idx_o         (idx_out),
        .ram_we_o      (ram_we_out),
        .ram_oe_o      (ram_oe_out),
        .par_err_o     (par_err_out),
        .mchk_o        (mchk_out)
    );

    assign slot_busy_out = busy;

    // Bus ownership for the next cycle: release whenever the system asks.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_drive_out <= 1'b0;
        else        bus_drive_out <= !bus_req_in;
    end

    // R1
    drv_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_in |=> !bus_drive_out);

    // R1
    drv_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req_in |=> bus_drive_out);

    // R10
    we_oe_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we_out && ram_oe_out));
endmodule

// File: tb/sim_fill_bus_ctrl.sv
module sim_fill_bus_ctrl;
    localparam int IDX_W  = 22;
    localparam int DATA_W = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic miss_req = 1'b0, fill = 1'b0, fsel = 1'b0, dack = 1'b0, breq = 1'b0;
    logic idle = 1'b0, nochk = 1'b0, ferr = 1'b0, rreq = 1'b0;
    logic [IDX_W-1:0]    maddr = '0, ridx = '0;
    logic [DATA_W-1:0]   data = '0;
    logic [DATA_W/8-1:0] chk = '0;

    logic grant, we, oe, drv, perr, mchk;
    logic [1:0] busy;
    logic [IDX_W-1:0] idx;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit cmp_on = 0;

    always #5 clk = ~clk;

    fill_bus_ctrl #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .miss_req_in(miss_req), .miss_addr_in(maddr), .miss_grant_out(grant),
        .slot_busy_out(busy), .fill_in(fill), .fill_id_in(fsel), .dack_in(dack),
        .bus_req_in(breq), .cache_idle_in(idle), .nocheck_in(nochk),
        .fill_err_in(ferr), .data_in(data), .check_in(chk),
        .rd_req_in(rreq), .rd_idx_in(ridx), .idx_out(idx),
        .ram_we_out(we), .ram_oe_out(oe), .bus_drive_out(drv),
        .par_err_out(perr), .mchk_out(mchk)
    );

    // Behavioural reference model
    int m_mode;               // 0 idle, 1 write, 2 wait, 3 read
    bit [1:0] m_busy;
    logic [IDX_W-1:0] m_addr [2];
    bit m_pend, m_pslot, m_cur;
    logic [IDX_W-1:0] m_idx;
    bit e_we, e_oe, e_drv, e_par, e_mch;
    bit t_dc, t_bad, t_live, t_cv, t_cs;
    bit [1:0] t_nb;
    int t_slot;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_busy = 2'b00; m_pend = 0; m_pslot = 0; m_cur = 0;
            m_addr[0] = '0; m_addr[1] = '0; m_idx = '0;
            e_we = 0; e_oe = 0; e_drv = 0; e_par = 0; e_mch = 0;
        end else begin
            t_dc = (m_mode == 1) && dack;
            t_bad = 0;
            for (int b = 0; b < DATA_W/8; b++)
                if ((^data[8*b +: 8]) != chk[b]) t_bad = 1;
            e_par = t_dc && !nochk && t_bad;
            e_mch = t_dc && ferr;
            e_drv = !breq;
            t_live = fill && m_busy[fsel];
            t_cv = m_pend || t_live;
            t_cs = m_pend ? m_pslot : fsel;
            t_nb = m_busy;
            if (t_dc) t_nb[m_cur] = 0;
            e_we = 0; e_oe = 0;
            if (m_mode == 0 || m_mode == 3) begin
                if (t_cv && !idle) begin
                    m_mode = 1; e_we = 1; m_idx = m_addr[t_cs]; m_cur = t_cs; m_pend = 0;
                end else if (t_cv) begin
                    m_pend = 1; m_pslot = t_cs; m_mode = 0;
                end else if (rreq && !idle) begin
                    m_mode = 3; e_oe = 1; m_idx = ridx;
                end else m_mode = 0;
            end else if (m_mode == 1) begin
                if (t_live && !m_pend) begin m_pend = 1; m_pslot = fsel; end
                m_mode = dack ? 0 : 2;
            end else begin
                if (t_live && !m_pend) begin m_pend = 1; m_pslot = fsel; end
                if (!idle) begin m_mode = 1; e_we = 1; end
            end
            t_slot = -1;
            for (int i = 0; i < 2; i++) if (!m_busy[i] && t_slot < 0) t_slot = i;
            if (miss_req && t_slot >= 0) begin
                t_nb[t_slot] = 1; m_addr[t_slot] = maddr;
            end
            m_busy = t_nb;
        end
    end

    task automatic chk_val(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            chk_val("R1 bus drive", 64'(drv), 64'(e_drv));
            chk_val("R2/R3 write enable", 64'(we), 64'(e_we));
            chk_val("R10 output enable", 64'(oe), 64'(e_oe));
            chk_val("R4/R6 busy bits", 64'(busy), 64'(m_busy));
            chk_val("R6 grant", 64'(grant), 64'(!(m_busy[0] && m_busy[1])));
            chk_val("R7 parity flag", 64'(perr), 64'(e_par));
            chk_val("R9 machine check", 64'(mchk), 64'(e_mch));
            if (e_we || e_oe) chk_val("R2/R10 index", 64'(idx), 64'(m_idx));
            chk_val("R10 we/oe exclusive", 64'(we && oe), 64'd0);
        end
    end

    function automatic logic [DATA_W/8-1:0] good_chk(input logic [DATA_W-1:0] d);
        logic [DATA_W/8-1:0] c;
        for (int b = 0; b < DATA_W/8; b++) c[b] = ^d[8*b +: 8];
        return c;
    endfunction

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) step();
        // R11: reset state
        chk_val("R11 reset we", 64'(we), 64'd0);
        chk_val("R11 reset oe", 64'(oe), 64'd0);
        chk_val("R11 reset busy", 64'(busy), 64'd0);
        chk_val("R11 reset flags", 64'({perr, mchk}), 64'd0);
        rst_n = 1'b1;
        cmp_on = 1;
        // R1: toggle bus request
        for (int i = 0; i < 6; i++) begin breq = i[0]; step(); end
        breq = 1'b1; step(); step(); breq = 1'b0;
        // R6: fill both slots, then a third request is ignored
        miss_req = 1; maddr = 22'h0A0A0; step();
        maddr = 22'h1B1B1; step();
        maddr = 22'h2C2C2;
        chk_val("R6 grant low when full", 64'(grant), 64'd0);
        step();
        chk_val("R6 full request ignored", 64'(busy), 64'd3);
        miss_req = 0; step();
        // R2/R4: fill slot 1 acknowledged at once
        fill = 1; fsel = 1; step();
        chk_val("R2 write started", 64'(we), 64'd1);
        chk_val("R2 slot 1 index", 64'(idx), 64'h1B1B1);
        fill = 0; dack = 1; data = {4{32'hDEADBEEF}}; chk = good_chk(data); step();
        chk_val("R4 slot 1 freed", 64'(busy), 64'd1);
        dack = 0; step(); step();
        // R3: fill slot 0 acknowledged only on the second write attempt
        fill = 1; fsel = 0; step();
        fill = 0; step();
        chk_val("R3 gap cycle", 64'(we), 64'd0);
        step();
        chk_val("R3 retry write", 64'(we), 64'd1);
        chk_val("R3 retry index", 64'(idx), 64'h0A0A0);
        dack = 1; data = {8{16'h1357}}; chk = good_chk(data); step();
        dack = 0; step();
        // R12: fill for a free slot
        fill = 1; fsel = 0; step();
        fill = 0;
        chk_val("R12 free slot fill ignored", 64'(we), 64'd0);
        step();
        // R7: bad parity
        miss_req = 1; maddr = 22'h03333; step();
        maddr = 22'h04444; step(); miss_req = 0;
        fill = 1; fsel = 0; step();
        fill = 0; dack = 1; data = {16{8'hA5}}; chk = good_chk(data) ^ 16'h0100; step();
        chk_val("R7 parity error flagged", 64'(perr), 64'd1);
        dack = 0; step();
        chk_val("R7 parity pulse ends", 64'(perr), 64'd0);
        // R8: nocheck suppresses
        fill = 1; fsel = 1; step();
        fill = 0; dack = 1; nochk = 1; chk = 16'hFFFF ^ good_chk(data); step();
        chk_val("R8 nocheck suppresses", 64'(perr), 64'd0);
        dack = 0; nochk = 0; step();
        // R9: fill error on two separate fills
        for (int k = 0; k < 2; k++) begin
            miss_req = 1; maddr = 22'(22'h05000 + k); step(); miss_req = 0;
            fill = 1; fsel = 0; step();
            fill = 0; dack = 1; ferr = 1; chk = good_chk(data); step();
            chk_val("R9 machine check pulse", 64'(mchk), 64'd1);
            dack = 0; ferr = 0; step();
            chk_val("R9 pulse ends", 64'(mchk), 64'd0);
        end
        // R5: idle-cache defers a fill and blocks reads
        miss_req = 1; maddr = 22'h06666; step(); miss_req = 0;
        idle = 1; fill = 1; fsel = 0; step();
        fill = 0; step();
        chk_val("R5 no write while idle", 64'(we), 64'd0);
        rreq = 1; ridx = 22'h07777; step();
        chk_val("R5 no read while idle", 64'(oe), 64'd0);
        rreq = 0; idle = 0; step();
        chk_val("R5 deferred write starts", 64'(we), 64'd1);
        chk_val("R5 deferred index", 64'(idx), 64'h06666);
        dack = 1; step(); dack = 0; step();
        // R5: idle during a retry wait
        miss_req = 1; maddr = 22'h08888; step(); miss_req = 0;
        fill = 1; fsel = 0; step();
        fill = 0; idle = 1; step();
        step();
        chk_val("R5 retry held while idle", 64'(we), 64'd0);
        idle = 0; step();
        chk_val("R5 retry after idle", 64'(we), 64'd1);
        dack = 1; step(); dack = 0; step();
        // R10: read
        rreq = 1; ridx = 22'h09999; step();
        chk_val("R10 read enable", 64'(oe), 64'd1);
        chk_val("R10 read index", 64'(idx), 64'h09999);
        rreq = 0; step();
        chk_val("R10 read is one cycle", 64'(oe), 64'd0);
        repeat (4) step();
        summary();
    end
endmodule